// File: doc/BRIEF.md
# Interrupt and Barrier Register Bank

This block holds three software-visible registers for one processor module: one collecting interrupts from other processors, one collecting device-completion interrupts, and one gathering barrier arrivals. Requests arriving from the interconnect never replace a register's value. Their data pattern is OR-merged into it, so several senders can post distinct bits without losing one another's. A local processor read returns the register's value and empties it in the same operation. The processor therefore sees every posted bit exactly once.

Each of the two interrupt registers drives its own level interrupt line. The barrier register takes writes in the same way but never interrupts. Instead, it raises a completion flag once every bit of a configured participant mask has arrived. Cross-processor and barrier writes may be multicast. Each carries a station routing mask and a per-station processor mask, and this module accepts the write only when both masks select it.

Top module: `intr_barrier_bank`

## Requirements
- R1: A write accepted into any register leaves it holding the bitwise OR of its previous value and the write data, visible from the cycle after the write.
- R2: Any accepted write to an interrupt register, including one with all-zero data, drives that register's interrupt output high from the next cycle. The output stays high until a read clears the register.
- R3: While `rd_valid_i` is high, `rd_data_o` shows the selected register's current value in the same cycle. The register is zero from the next cycle, and its interrupt output drops at that point unless a write coincided with the read.
- R4: Select code 0 addresses the cross-processor register, which drives `xirq_o`. Select code 1 addresses the device register, which drives `dirq_o`. A write to one register never changes the other register or its interrupt line.
- R5: Select code 2 addresses the barrier register. It merges and clears like the others, but writes to it never raise `xirq_o` or `dirq_o`.
- R6: Writes with select code 0 or 2 are accepted only when `wr_route_i[station_id_i]` and `wr_procs_i[proc_id_i]` are both 1. Otherwise they have no effect. Device writes (code 1) are accepted regardless of the masks.
- R7: `bar_done_o` is high exactly when `bar_mask_i` is nonzero and every bit set in `bar_mask_i` is also set in the barrier register.
- R8: When an accepted write and a read hit the same register in one cycle, the read returns the old value. The register then holds exactly the newly written bits, and for an interrupt register the interrupt output stays high.
- R9: Select code 3 addresses no register. A write with it changes nothing, and a read with it returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_id_i | input | $clog2(NUM_STATIONS) | This module's station number |
| proc_id_i | input | $clog2(PROCS_PER_STN) | This processor's index within its station |
| wr_valid_i | input | 1 | Incoming write request |
| wr_sel_i | input | 2 | Register select of the write |
| wr_data_i | input | DATA_W | Pattern to OR into the register |
| wr_route_i | input | NUM_STATIONS | Station routing mask of the write |
| wr_procs_i | input | PROCS_PER_STN | Per-station processor mask of the write |
| rd_valid_i | input | 1 | Local read-and-clear request |
| rd_sel_i | input | 2 | Register select of the read |
| rd_data_o | output | DATA_W | Value of the read register, same cycle |
| bar_mask_i | input | DATA_W | Participant mask for barrier completion |
| xirq_o | output | 1 | Cross-processor interrupt, level |
| dirq_o | output | 1 | Device interrupt, level |
| bar_done_o | output | 1 | All participants have arrived |

## Verification
A wrong register state reaches the ports quickly. An interrupt line that is stuck or missing is wrong one cycle after the triggering write. Lost or extra bits appear at `rd_data_o` on the next read. A clear that fails shows up as a nonzero value on the following read. A misdecoded target mask lets a write land in a register it should not reach. The bench sweeps every station and processor identity against every routing and processor mask, and each such mistake is caught within two cycles by reading the register back.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  typedef enum logic [1:0] {
    SEL_XPROC = 2'd0,
    SEL_DEV   = 2'd1,
    SEL_BAR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int NUM_REGS = 3;
endpackage

// File: rtl/ibb_target_decode.sv
module ibb_target_decode
  import ibb_pkg::*;
#(
  parameter int NUM_STATIONS  = 4,
  parameter int PROCS_PER_STN = 4,
  localparam int SW = (NUM_STATIONS  > 1) ? $clog2(NUM_STATIONS)  : 1,
  localparam int PW = (PROCS_PER_STN > 1) ? $clog2(PROCS_PER_STN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_valid_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [NUM_STATIONS-1:0]  wr_route_i,
  input  logic [PROCS_PER_STN-1:0] wr_procs_i,
  input  logic [SW-1:0]            station_id_i,
  input  logic [PW-1:0]            proc_id_i,
  output logic [NUM_REGS-1:0]      wr_en_o
);
  logic stn_hit, proc_hit, targeted;

  assign stn_hit  = (int'(station_id_i) < NUM_STATIONS)  && wr_route_i[station_id_i];
  assign proc_hit = (int'(proc_id_i)    < PROCS_PER_STN) && wr_procs_i[proc_id_i];
  assign targeted = stn_hit && proc_hit;

  always_comb begin
    wr_en_o = '0;
    if (wr_valid_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_XPROC: wr_en_o[SEL_XPROC] = targeted;
        SEL_DEV:   wr_en_o[SEL_DEV]   = 1'b1;
        SEL_BAR:   wr_en_o[SEL_BAR]   = targeted;
        default:   wr_en_o            = '0;
      endcase
    end
  end

  // at most one register written per request
  p_single_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  // multicast writes need both masks to select this module
  p_mask_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o[SEL_XPROC] || wr_en_o[SEL_BAR]) |-> (|wr_route_i) && (|wr_procs_i));
endmodule

// File: rtl/ibb_or_clear_reg.sv
module ibb_or_clear_reg #(
  parameter int DATA_W  = 32,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] q_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (rd_en_i) begin
      q <= wr_en_i ? wr_data_i : '0;  // coincident write survives the clear
    end else if (wr_en_i) begin
      q <= q | wr_data_i;
    end
  end

  assign q_o = q;

  generate
    if (HAS_IRQ) begin : g_irq
      logic pend;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend <= 1'b0;
        else if (wr_en_i) pend <= 1'b1;
        else if (rd_en_i) pend <= 1'b0;
      end
      assign irq_o = pend;

      p_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> irq_o);
      p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !wr_en_i) |=> !irq_o);
      p_irq_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|q_o) |-> irq_o);
    end else begin : g_no_irq
      assign irq_o = 1'b0;
    end
  endgenerate

  p_keep_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ((q_o & $past(q_o)) == $past(q_o)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> (q_o == '0));
  p_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i) |=> (q_o == $past(wr_data_i)));
endmodule

// File: rtl/ibb_barrier_detect.sv
module ibb_barrier_detect #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] bar_q_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              done_o
);
  assign done_o = (|mask_i) && ((bar_q_i & mask_i) == mask_i);
endmodule

// File: rtl/intr_barrier_bank.sv
module intr_barrier_bank
  import ibb_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int NUM_STATIONS  = 4,
  parameter int PROCS_PER_STN = 4,
  localparam int SW = (NUM_STATIONS  > 1) ? $clog2(NUM_STATIONS)  : 1,
  localparam int PW = (PROCS_PER_STN > 1) ? $clog2(PROCS_PER_STN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SW-1:0]            station_id_i,
  input  logic [PW-1:0]            proc_id_i,
  input  logic                     wr_valid_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [NUM_STATIONS-1:0]  wr_route_i,
  input  logic [PROCS_PER_STN-1:0] wr_procs_i,
  input  logic                     rd_valid_i,
  input  logic [1:0]               rd_sel_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic [DATA_W-1:0]        bar_mask_i,
  output logic                     xirq_o,
  output logic                     dirq_o,
  output logic                     bar_done_o
);
  logic [NUM_REGS-1:0] wr_en, rd_en, irq;
  logic [DATA_W-1:0]   q [NUM_REGS];

  ibb_target_decode #(
    .NUM_STATIONS (NUM_STATIONS),
    .PROCS_PER_STN(PROCS_PER_STN)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_sel_i    (wr_sel_i),
    .wr_route_i  (wr_route_i),
    .wr_procs_i  (wr_procs_i),
    .station_id_i(station_id_i),
    .proc_id_i   (proc_id_i),
    .wr_en_o     (wr_en)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign rd_en[i] = rd_valid_i && (rd_sel_i == 2'(i));
      ibb_or_clear_reg #(
        .DATA_W (DATA_W),
        .HAS_IRQ(i != int'(SEL_BAR))
      ) u_reg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en[i]),
        .wr_data_i(wr_data_i),
        .rd_en_i  (rd_en[i]),
        .q_o      (q[i]),
        .irq_o    (irq[i])
      );
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_en[i]) rd_data_o = q[i];
  end

  assign xirq_o = irq[SEL_XPROC];
  assign dirq_o = irq[SEL_DEV];

  ibb_barrier_detect #(.DATA_W(DATA_W)) u_bar_done (
    .bar_q_i(q[SEL_BAR]),
    .mask_i (bar_mask_i),
    .done_o (bar_done_o)
  );

  // barrier traffic never disturbs the interrupt lines
  p_bar_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en[SEL_BAR] && !wr_en[SEL_XPROC] && !rd_en[SEL_XPROC] &&
     !wr_en[SEL_DEV] && !rd_en[SEL_DEV]) |=> ($stable(xirq_o) && $stable(dirq_o)));
  // device writes leave the cross-processor line alone
  p_dev_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en[SEL_XPROC] && !rd_en[SEL_XPROC]) |=> $stable(xirq_o));
  // completion holds until the barrier register is read or the mask moves
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar_done_o && !rd_en[SEL_BAR]) |=> (bar_done_o || !$stable(bar_mask_i)));
  p_none_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_sel_i == 2'd3) |-> (rd_data_o == '0));
endmodule

// File: tb/intr_barrier_bank_bench.sv
`timescale 1ns/1ps
module intr_barrier_bank_bench;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sid = '0, pid = '0;
  logic          wv = 1'b0, rv = 1'b0;
  logic [1:0]    wsel = '0, rsel = '0;
  logic [DW-1:0] wdata = '0, bmask = '0, rd_data, last_rd;
  logic [NS-1:0] route = '0;
  logic [NP-1:0] procs = '0;
  logic          xirq, dirq, bdone;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  intr_barrier_bank #(.DATA_W(DW), .NUM_STATIONS(NS), .PROCS_PER_STN(NP)) u_intr_barrier_bank (
    .clk_i(clk), .rst_ni(rst_n), .station_id_i(sid), .proc_id_i(pid),
    .wr_valid_i(wv), .wr_sel_i(wsel), .wr_data_i(wdata), .wr_route_i(route), .wr_procs_i(procs),
    .rd_valid_i(rv), .rd_sel_i(rsel), .rd_data_o(rd_data), .bar_mask_i(bmask),
    .xirq_o(xirq), .dirq_o(dirq), .bar_done_o(bdone)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one clock of optional write and optional read; read data captured mid-cycle
  task automatic op(input bit do_w, input logic [1:0] ws, input logic [DW-1:0] wd,
                    input logic [NS-1:0] rt, input logic [NP-1:0] pm,
                    input bit do_r, input logic [1:0] rs);
    @(negedge clk);
    wv = do_w; wsel = ws; wdata = wd; route = rt; procs = pm;
    rv = do_r; rsel = rs;
    #1 last_rd = rd_data;
    @(negedge clk);
    wv = 1'b0; rv = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
    op(1'b1, s, d, '1, '1, 1'b0, 2'd0);
  endtask

  task automatic rd(input logic [1:0] s);
    op(1'b0, 2'd0, '0, '0, '0, 1'b1, s);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset xirq", {31'b0, xirq}, 0);
    chk("reset dirq", {31'b0, dirq}, 0);
    chk("reset bar_done", {31'b0, bdone}, 0);
    rd(2'd0); chk("reset xproc reg R3", last_rd, 0);

    // R1 OR merge and R2 interrupt on device register
    wr(2'd1, 32'h0000_00F0);
    chk("R2 dirq after write", {31'b0, dirq}, 1);
    chk("R4 xirq untouched by device write", {31'b0, xirq}, 0);
    wr(2'd1, 32'h0000_0F0F);
    rd(2'd1);
    chk("R1 OR merge", last_rd, 32'h0000_0FFF);
    chk("R3 dirq drops after read", {31'b0, dirq}, 0);
    rd(2'd1); chk("R3 cleared", last_rd, 0);

    // R2 zero-data write still interrupts
    wr(2'd0, 32'h0);
    chk("R2 zero write raises xirq", {31'b0, xirq}, 1);
    chk("R4 dirq untouched by xproc write", {31'b0, dirq}, 0);
    rd(2'd0);
    chk("R3 zero read value", last_rd, 0);
    chk("R3 xirq drops", {31'b0, xirq}, 0);

    // R8 collision
    wr(2'd1, 32'hA5A5_0000);
    op(1'b1, 2'd1, 32'h0000_1234, '1, '1, 1'b1, 2'd1);
    chk("R8 read returns old", last_rd, 32'hA5A5_0000);
    chk("R8 irq held", {31'b0, dirq}, 1);
    rd(2'd1);
    chk("R8 only new bits kept", last_rd, 32'h0000_1234);

    // R9 unused select
    wr(2'd2, 32'h8);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R9 write ignored xirq", {31'b0, xirq}, 0);
    chk("R9 write ignored dirq", {31'b0, dirq}, 0);
    rd(2'd3); chk("R9 read zero", last_rd, 0);
    rd(2'd2); chk("R9 barrier untouched", last_rd, 32'h8);

    // R5 / R7 barrier accumulation
    bmask = 32'h0000_000F;
    for (int b = 0; b < 4; b++) begin
      chk("R7 not done yet", {31'b0, bdone}, 0);
      wr(2'd2, 32'h1 << b);
      chk("R5 no xirq", {31'b0, xirq}, 0);
      chk("R5 no dirq", {31'b0, dirq}, 0);
    end
    chk("R7 done when all set", {31'b0, bdone}, 1);
    bmask = 32'h0000_001F; #1;
    chk("R7 wider mask not done", {31'b0, bdone}, 0);
    bmask = '0; #1;
    chk("R7 empty mask never done", {31'b0, bdone}, 0);
    bmask = 32'h0000_000F;
    rd(2'd2);
    chk("R5 barrier read value", last_rd, 32'h0000_000F);
    chk("R7 done drops after clear", {31'b0, bdone}, 0);

    // R6 device write ignores masks
    op(1'b1, 2'd1, 32'h77, '0, '0, 1'b0, 2'd0);
    chk("R6 device unconditional", {31'b0, dirq}, 1);
    rd(2'd1); chk("R6 device data", last_rd, 32'h77);

    // R6 exhaustive targeting sweep on xproc and barrier
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < NP; p++) begin
        sid = 2'(s); pid = 2'(p);
        for (int r = 0; r < (1 << NS); r++) begin
          for (int m = 0; m < (1 << NP); m++) begin
            logic acc;
            logic [DW-1:0] d;
            acc = r[s] && m[p];
            d = 32'h1000_0000 | (s << 12) | (p << 8) | (r << 4) | m;
            op(1'b1, (m[0] ? 2'd2 : 2'd0), d, NS'(r), NP'(m), 1'b0, 2'd0);
            if (!m[0]) chk("R6 xirq on target match", {31'b0, xirq}, {31'b0, acc});
            rd(m[0] ? 2'd2 : 2'd0);
            chk("R6 accepted data", last_rd, acc ? d : '0);
          end
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule